// File: doc/BRIEF.md
# Scoreboarded Warp Instruction Scheduler

This block sits between a fetch stage and the lane datapath of a multithreaded shader core. Each of its warp slots holds a single buffered instruction. Every cycle it picks one warp whose instruction has no register hazard and issues it. A fetch stage writes at most one instruction per cycle into whichever slot is empty. A per-warp register scoreboard marks an issued instruction's destination register as pending. The register stays pending until a writeback naming that warp and register comes back. A warp that is waiting on a slow result therefore never holds back the other warps.

An issued instruction occupies the dispatch stage for a fixed number of beats. In each beat one group of lanes receives it, so after the last beat all 32 lanes of the warp have the same instruction. A new warp is selected during the final beat of the current one, so consecutive dispatches follow each other without a gap and a change of warp costs nothing. A mode input picks the selection policy. Round-robin starts its search just past the warp that issued last. Oldest-first picks the slot that has waited longest since it was filled.

Top module: `warp_issue_sched`

## Requirements
- R1: Out of reset `disp_valid` is low, and it stays low for as long as no slot has been filled.
- R2: A fill aimed at an empty slot is stored. A fill aimed at a slot that still holds an unissued instruction is ignored, and the stored instruction is the one that later issues.
- R3: An instruction is not issued while either of its enabled source registers is pending in its own warp's scoreboard.
- R4: An instruction whose enabled destination register is already pending in its warp's scoreboard is not issued.
- R5: Issuing an instruction with an enabled destination marks that register pending for that warp only. A writeback of (warp, register) clears it. A writeback of a different register of the same warp does not release a waiting instruction.
- R6: Each issued instruction is presented for exactly 4 consecutive cycles, with `disp_beat` counting 0, 1, 2, 3 and with warp and opcode held stable. During beat b, `disp_lane_mask` has ones at bits 8b through 8b+7 and zeros elsewhere.
- R7: With the dispatcher idle, an instruction filled at clock edge k shows beat 0 after edge k+1. When another instruction is eligible, its beat 0 follows the previous beat 3 directly, so issues are 4 cycles apart.
- R8: With `pick_mode` = 0 (round-robin), the search starts at the slot just after the warp that issued last and wraps from slot 23 to slot 0.
- R9: With `pick_mode` = 1 (oldest-first), the eligible slot that has held its instruction longest is issued first.
- R10: A warp blocked by its scoreboard does not stop an eligible instruction in another warp from issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pick_mode | input | 1 | 0 = round-robin, 1 = oldest-first |
| fill_valid | input | 1 | Writes an instruction into a slot this cycle |
| fill_warp | input | 5 | Target warp slot |
| fill_op | input | 8 | Opcode payload |
| fill_dst | input | 4 | Destination register index |
| fill_dst_en | input | 1 | Instruction writes a destination register |
| fill_src_a | input | 4 | First source register index |
| fill_src_a_en | input | 1 | First source is read |
| fill_src_b | input | 4 | Second source register index |
| fill_src_b_en | input | 1 | Second source is read |
| wb_valid | input | 1 | A result is written back this cycle |
| wb_warp | input | 5 | Warp of the written-back register |
| wb_reg | input | 4 | Index of the written-back register |
| disp_valid | output | 1 | A dispatch beat is active |
| disp_beat | output | 2 | Beat number within the dispatch |
| disp_warp | output | 5 | Warp being dispatched |
| disp_op | output | 8 | Opcode being dispatched |
| disp_dst | output | 4 | Destination register of the dispatched instruction |
| disp_dst_en | output | 1 | Dispatched instruction writes a destination |
| disp_lane_mask | output | 32 | Lanes receiving the instruction in this beat |

## Verification
The bench pins down the issue order of three warps that were filled out of index order, once under each policy. A pointer that does not advance past the last issuer, or an age comparison that is reversed, shows up as a wrong sequence. It writes back the wrong register of a blocked warp to catch a scoreboard that clears too much, and it lets a second warp read the same register number to catch a scoreboard that is not kept per warp. It also refills an occupied slot with a hazard-free instruction, which exposes a buffer that overwrites instead of ignoring. Finally it measures the spacing of beat 0 between issues, which exposes an idle cycle between dispatches or a beat count that is off by one.

// File: rtl/wis_pkg.sv
// Shared widths and types for the warp issue scheduler.
// Assumes a fixed architectural register count per warp.
package wis_pkg;
    localparam int REGS   = 16;
    localparam int RIDX_W = $clog2(REGS);
    localparam int OP_W   = 8;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [RIDX_W-1:0] dst;
        logic              dst_en;
        logic [RIDX_W-1:0] src_a;
        logic              src_a_en;
        logic [RIDX_W-1:0] src_b;
        logic              src_b_en;
    } winstr_t;

    typedef enum logic {
        PICK_ROUND_ROBIN = 1'b0,
        PICK_OLDEST      = 1'b1
    } pick_mode_e;
endpackage

// File: rtl/wis_ibuf.sv
// Instruction buffer: one instruction per warp slot, plus a saturating
// wait counter per slot. Assumes at most one fill and one issue per cycle.
// A fill into an occupied slot is dropped.
module wis_ibuf
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int AGE_W     = 6,
    localparam int WID_W    = $clog2(NUM_WARPS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            fill_valid,
    input  logic [WID_W-1:0]                fill_warp,
    input  winstr_t                         fill_instr,
    input  logic                            take_valid,
    input  logic [WID_W-1:0]                take_warp,
    output logic [NUM_WARPS-1:0]            slot_vld,
    output winstr_t [NUM_WARPS-1:0]         slot_instr,
    output logic [NUM_WARPS-1:0][AGE_W-1:0] slot_age
);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    for (genvar i = 0; i < NUM_WARPS; i++) begin : g_slot
        // Per slot: clear on issue, load on fill into an empty slot, age while waiting.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vld[i]   <= 1'b0;
                slot_instr[i] <= '0;
                slot_age[i]   <= '0;
            end else if (take_valid && take_warp == WID_W'(i)) begin
                slot_vld[i] <= 1'b0;
            end else if (fill_valid && fill_warp == WID_W'(i) && !slot_vld[i]) begin
                slot_vld[i]   <= 1'b1;
                slot_instr[i] <= fill_instr;
                slot_age[i]   <= '0;
            end else if (slot_vld[i] && slot_age[i] != AGE_MAX) begin
                slot_age[i] <= slot_age[i] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wis_scoreboard.sv
// Register scoreboard: one pending bit per register per warp.
// Set on issue, cleared on writeback; set wins if both hit one bit.
module wis_scoreboard
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    localparam int WID_W    = $clog2(NUM_WARPS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           set_en,
    input  logic [WID_W-1:0]               set_warp,
    input  logic [RIDX_W-1:0]              set_reg,
    input  logic                           clr_en,
    input  logic [WID_W-1:0]               clr_warp,
    input  logic [RIDX_W-1:0]              clr_reg,
    output logic [NUM_WARPS-1:0][REGS-1:0] pend
);
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        for (genvar r = 0; r < REGS; r++) begin : g_reg
            // One pending bit: issue marks it, matching writeback releases it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend[w][r] <= 1'b0;
                else if (set_en && set_warp == WID_W'(w) && set_reg == RIDX_W'(r))
                    pend[w][r] <= 1'b1;
                else if (clr_en && clr_warp == WID_W'(w) && clr_reg == RIDX_W'(r))
                    pend[w][r] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wis_picker.sv
// Selects one eligible warp: round-robin from the slot after the last
// issuer, or the slot with the largest wait count (lowest index on a tie).
module wis_picker
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int AGE_W     = 6,
    localparam int WID_W    = $clog2(NUM_WARPS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  pick_mode_e                      mode,
    input  logic [NUM_WARPS-1:0]            elig,
    input  logic [NUM_WARPS-1:0][AGE_W-1:0] age,
    input  logic                            advance,
    output logic                            pick_any,
    output logic [WID_W-1:0]                pick_idx
);
    logic [WID_W-1:0] rr_ptr;
    logic [WID_W-1:0] rr_idx;
    logic [WID_W-1:0] old_idx;
    logic             rr_found;

    // Rotating search starting at the pointer.
    always_comb begin
        rr_found = 1'b0;
        rr_idx   = '0;
        for (int k = 0; k < NUM_WARPS; k++) begin
            int idx;
            idx = int'(rr_ptr) + k;
            if (idx >= NUM_WARPS) idx = idx - NUM_WARPS;
            if (!rr_found && elig[idx]) begin
                rr_found = 1'b1;
                rr_idx   = WID_W'(idx);
            end
        end
    end

    // Oldest eligible slot; strict compare keeps the lowest index on ties.
    always_comb begin
        logic             seen;
        logic [AGE_W-1:0] best;
        seen    = 1'b0;
        best    = '0;
        old_idx = '0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            if (elig[i] && (!seen || age[i] > best)) begin
                seen    = 1'b1;
                best    = age[i];
                old_idx = WID_W'(i);
            end
        end
    end

    assign pick_any = rr_found;
    assign pick_idx = (mode == PICK_OLDEST) ? old_idx : rr_idx;

    // Pointer moves to the slot after whichever warp just issued.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (advance)
            rr_ptr <= (int'(pick_idx) == NUM_WARPS - 1) ? '0 : pick_idx + 1'b1;
    end
endmodule

// File: rtl/wis_dispatch.sv
// Multi-beat dispatch: holds one issued instruction for BEATS cycles and
// steps a lane-group mask so every lane sees it once. Accepts a new
// instruction during the last beat so consecutive issues have no gap.
module wis_dispatch
    import wis_pkg::*;
#(
    parameter int BEATS  = 4,
    parameter int LANES  = 32,
    parameter int WID_W  = 5,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int GROUP  = LANES / BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [WID_W-1:0]  launch_warp,
    input  logic [OP_W-1:0]   launch_op,
    input  logic [RIDX_W-1:0] launch_dst,
    input  logic              launch_dst_en,
    output logic              can_accept,
    output logic              disp_valid,
    output logic [BEAT_W-1:0] disp_beat,
    output logic [WID_W-1:0]  disp_warp,
    output logic [OP_W-1:0]   disp_op,
    output logic [RIDX_W-1:0] disp_dst,
    output logic              disp_dst_en,
    output logic [LANES-1:0]  disp_lane_mask
);
    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

    assign can_accept = !disp_valid || disp_beat == LAST;

    // Beat sequencer and held instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_valid  <= 1'b0;
            disp_beat   <= '0;
            disp_warp   <= '0;
            disp_op     <= '0;
            disp_dst    <= '0;
            disp_dst_en <= 1'b0;
        end else if (launch) begin
            disp_valid  <= 1'b1;
            disp_beat   <= '0;
            disp_warp   <= launch_warp;
            disp_op     <= launch_op;
            disp_dst    <= launch_dst;
            disp_dst_en <= launch_dst_en;
        end else if (disp_valid && disp_beat == LAST) begin
            disp_valid <= 1'b0;
            disp_beat  <= '0;
        end else if (disp_valid) begin
            disp_beat <= disp_beat + 1'b1;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Lane l is covered in the beat equal to its lane group.
        assign disp_lane_mask[l] = disp_valid && (int'(disp_beat) == l / GROUP);
    end
endmodule

// File: rtl/warp_issue_sched.sv
// Top of the warp issue scheduler: instruction buffer, per-warp
// scoreboard, priority picker and multi-beat dispatcher. Assumes fills
// and writebacks are single-cycle pulses with in-range warp ids.
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_WARPS      = 24,
    parameter int DISPATCH_BEATS = 4,
    parameter int LANES          = 32,
    parameter int AGE_W          = 6,
    localparam int WID_W         = $clog2(NUM_WARPS),
    localparam int BEAT_W        = (DISPATCH_BEATS > 1) ? $clog2(DISPATCH_BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pick_mode,
    input  logic              fill_valid,
    input  logic [WID_W-1:0]  fill_warp,
    input  logic [OP_W-1:0]   fill_op,
    input  logic [RIDX_W-1:0] fill_dst,
    input  logic              fill_dst_en,
    input  logic [RIDX_W-1:0] fill_src_a,
    input  logic              fill_src_a_en,
    input  logic [RIDX_W-1:0] fill_src_b,
    input  logic              fill_src_b_en,
    input  logic              wb_valid,
    input  logic [WID_W-1:0]  wb_warp,
    input  logic [RIDX_W-1:0] wb_reg,
    output logic              disp_valid,
    output logic [BEAT_W-1:0] disp_beat,
    output logic [WID_W-1:0]  disp_warp,
    output logic [OP_W-1:0]   disp_op,
    output logic [RIDX_W-1:0] disp_dst,
    output logic              disp_dst_en,
    output logic [LANES-1:0]  disp_lane_mask
);
    winstr_t                         fill_instr;
    logic [NUM_WARPS-1:0]            slot_vld;
    winstr_t [NUM_WARPS-1:0]         slot_instr;
    logic [NUM_WARPS-1:0][AGE_W-1:0] slot_age;
    logic [NUM_WARPS-1:0][REGS-1:0]  sb_pend;
    logic [NUM_WARPS-1:0]            elig;
    logic                            pick_any;
    logic [WID_W-1:0]                pick_idx;
    winstr_t                         pick_instr;
    logic                            can_accept;
    logic                            issue_fire;

    assign fill_instr = '{op: fill_op, dst: fill_dst, dst_en: fill_dst_en,
                          src_a: fill_src_a, src_a_en: fill_src_a_en,
                          src_b: fill_src_b, src_b_en: fill_src_b_en};

    wis_ibuf #(.NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W)) u_ibuf (
        .clk, .rst_n,
        .fill_valid, .fill_warp, .fill_instr,
        .take_valid (issue_fire),
        .take_warp  (pick_idx),
        .slot_vld, .slot_instr, .slot_age
    );

    wis_scoreboard #(.NUM_WARPS(NUM_WARPS)) u_sb (
        .clk, .rst_n,
        .set_en   (issue_fire && pick_instr.dst_en),
        .set_warp (pick_idx),
        .set_reg  (pick_instr.dst),
        .clr_en   (wb_valid),
        .clr_warp (wb_warp),
        .clr_reg  (wb_reg),
        .pend     (sb_pend)
    );

    // Eligibility: occupied slot with no pending source or destination register.
    always_comb begin
        for (int w = 0; w < NUM_WARPS; w++) begin
            elig[w] = slot_vld[w]
                && !(slot_instr[w].src_a_en && sb_pend[w][slot_instr[w].src_a])
                && !(slot_instr[w].src_b_en && sb_pend[w][slot_instr[w].src_b])
                && !(slot_instr[w].dst_en   && sb_pend[w][slot_instr[w].dst]);
        end
    end

    wis_picker #(.NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W)) u_pick (
        .clk, .rst_n,
        .mode     (pick_mode_e'(pick_mode)),
        .elig,
        .age      (slot_age),
        .advance  (issue_fire),
        .pick_any,
        .pick_idx
    );

    assign pick_instr = slot_instr[pick_idx];
    assign issue_fire = pick_any && can_accept;

    wis_dispatch #(.BEATS(DISPATCH_BEATS), .LANES(LANES), .WID_W(WID_W)) u_disp (
        .clk, .rst_n,
        .launch        (issue_fire),
        .launch_warp   (pick_idx),
        .launch_op     (pick_instr.op),
        .launch_dst    (pick_instr.dst),
        .launch_dst_en (pick_instr.dst_en),
        .can_accept,
        .disp_valid, .disp_beat, .disp_warp, .disp_op,
        .disp_dst, .disp_dst_en, .disp_lane_mask
    );
endmodule

// File: rtl/wis_checker.sv
// Property checker for the warp issue scheduler, bound to its top.
module wis_checker
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int BEATS     = 4,
    localparam int WID_W    = $clog2(NUM_WARPS),
    localparam int BEAT_W   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           disp_valid,
    input logic [BEAT_W-1:0]              disp_beat,
    input logic [WID_W-1:0]               disp_warp,
    input logic [OP_W-1:0]                disp_op,
    input logic                           issue_fire,
    input logic [WID_W-1:0]               pick_idx,
    input winstr_t                        pick_instr,
    input logic [NUM_WARPS-1:0]           slot_vld,
    input logic [NUM_WARPS-1:0][REGS-1:0] sb_pend
);
    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !disp_valid);

    // R1
    issue_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |-> slot_vld[pick_idx]);

    // R3
    issue_src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |-> !(pick_instr.src_a_en && sb_pend[pick_idx][pick_instr.src_a])
                    && !(pick_instr.src_b_en && sb_pend[pick_idx][pick_instr.src_b]));

    // R4
    issue_dst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire && pick_instr.dst_en |-> !sb_pend[pick_idx][pick_instr.dst]);

    // R5
    dst_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire && pick_instr.dst_en |=> sb_pend[$past(pick_idx)][$past(pick_instr.dst)]);

    // R6
    beat_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && disp_beat != LAST && !issue_fire |=>
            disp_valid && disp_beat == BEAT_W'($past(disp_beat) + 1'b1)
            && $stable(disp_warp) && $stable(disp_op));

    // R7
    launch_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |=> disp_valid && disp_beat == '0 && disp_warp == $past(pick_idx));
endmodule

bind warp_issue_sched wis_checker #(
    .NUM_WARPS (NUM_WARPS),
    .BEATS     (DISPATCH_BEATS)
) i_wis_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_valid (disp_valid),
    .disp_beat  (disp_beat),
    .disp_warp  (disp_warp),
    .disp_op    (disp_op),
    .issue_fire (issue_fire),
    .pick_idx   (pick_idx),
    .pick_instr (pick_instr),
    .slot_vld   (slot_vld),
    .sb_pend    (sb_pend)
);

// File: tb/test_warp_issue_sched.sv
// Directed bench for the warp issue scheduler: one task per scenario.
module test_warp_issue_sched;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pick_mode;
    logic        fill_valid;
    logic [4:0]  fill_warp;
    logic [7:0]  fill_op;
    logic [3:0]  fill_dst;
    logic        fill_dst_en;
    logic [3:0]  fill_src_a;
    logic        fill_src_a_en;
    logic [3:0]  fill_src_b;
    logic        fill_src_b_en;
    logic        wb_valid;
    logic [4:0]  wb_warp;
    logic [3:0]  wb_reg;
    logic        disp_valid;
    logic [1:0]  disp_beat;
    logic [4:0]  disp_warp;
    logic [7:0]  disp_op;
    logic [3:0]  disp_dst;
    logic        disp_dst_en;
    logic [31:0] disp_lane_mask;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    warp_issue_sched i_warp_issue_sched (
        .clk, .rst_n, .pick_mode,
        .fill_valid, .fill_warp, .fill_op, .fill_dst, .fill_dst_en,
        .fill_src_a, .fill_src_a_en, .fill_src_b, .fill_src_b_en,
        .wb_valid, .wb_warp, .wb_reg,
        .disp_valid, .disp_beat, .disp_warp, .disp_op,
        .disp_dst, .disp_dst_en, .disp_lane_mask
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst_n = 1'b0; pick_mode = mode;
        fill_valid = 1'b0; fill_warp = '0; fill_op = '0;
        fill_dst = '0; fill_dst_en = 1'b0;
        fill_src_a = '0; fill_src_a_en = 1'b0;
        fill_src_b = '0; fill_src_b_en = 1'b0;
        wb_valid = 1'b0; wb_warp = '0; wb_reg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Called at a negedge; the fill lands on the next posedge.
    task automatic fill(input int w, input int op, input int d, input bit d_en,
                        input int a, input bit a_en, input int b, input bit b_en);
        fill_valid = 1'b1; fill_warp = 5'(w); fill_op = 8'(op);
        fill_dst = 4'(d); fill_dst_en = d_en;
        fill_src_a = 4'(a); fill_src_a_en = a_en;
        fill_src_b = 4'(b); fill_src_b_en = b_en;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic writeback(input int w, input int r);
        wb_valid = 1'b1; wb_warp = 5'(w); wb_reg = 4'(r);
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    // Waits for the next beat 0; returns warp -1 on timeout.
    task automatic wait_issue(input int limit, output int w, output int op, output int at);
        w = -1; op = -1; at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (disp_valid && disp_beat == 2'd0) begin
                w = int'(disp_warp); op = int'(disp_op); at = cyc;
                return;
            end
        end
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        chk("R1 idle after reset", disp_valid, 0);
        for (int i = 0; i < 6; i++) @(negedge clk);
        chk("R1 idle with empty slots", disp_valid, 0);
    endtask

    task automatic t_basic;
        do_reset(1'b0);
        fill(3, 8'h5A, 2, 1, 0, 0, 0, 0);
        @(negedge clk);
        chk("R7 issue one cycle after fill", disp_valid, 1);
        for (int b = 0; b < 4; b++) begin
            if (b > 0) @(negedge clk);
            chk("R6 beat number", disp_beat, b);
            chk("R6 warp held", disp_warp, 3);
            chk("R6 op held", disp_op, 8'h5A);
            chk("R6 lane mask", disp_lane_mask, 32'hFF << (8 * b));
        end
        @(negedge clk);
        chk("R6 ends after four beats", disp_valid, 0);
    endtask

    task automatic t_raw;
        int w, op, at;
        do_reset(1'b0);
        fill(5, 8'h10, 1, 1, 0, 0, 0, 0);
        wait_issue(4, w, op, at);
        chk("R5 producer issues", w, 5);
        fill(5, 8'h11, 0, 0, 1, 1, 0, 0);
        wait_issue(12, w, op, at);
        chk("R3 source pending blocks", w, -1);
        fill(6, 8'h20, 0, 0, 1, 1, 0, 0);
        wait_issue(6, w, op, at);
        chk("R10 other warp issues", w, 6);
        chk("R5 scoreboard per warp op", op, 8'h20);
        writeback(5, 2);
        wait_issue(10, w, op, at);
        chk("R5 wrong register keeps block", w, -1);
        writeback(5, 1);
        wait_issue(6, w, op, at);
        chk("R5 writeback releases", w, 5);
        chk("R5 released op", op, 8'h11);
        fill(9, 8'h30, 7, 1, 0, 0, 0, 0);
        wait_issue(6, w, op, at);
        fill(9, 8'h31, 0, 0, 0, 0, 7, 1);
        wait_issue(12, w, op, at);
        chk("R3 second source blocks", w, -1);
        writeback(9, 7);
        wait_issue(6, w, op, at);
        chk("R3 second source released", op, 8'h31);
    endtask

    task automatic t_waw;
        int w, op, at;
        do_reset(1'b0);
        fill(8, 8'h40, 4, 1, 0, 0, 0, 0);
        wait_issue(4, w, op, at);
        fill(8, 8'h41, 4, 1, 0, 0, 0, 0);
        wait_issue(12, w, op, at);
        chk("R4 destination pending blocks", w, -1);
        writeback(8, 4);
        wait_issue(6, w, op, at);
        chk("R4 destination released", op, 8'h41);
    endtask

    task automatic t_occupied;
        int w, op, at;
        do_reset(1'b0);
        fill(5, 8'h50, 1, 1, 0, 0, 0, 0);
        wait_issue(4, w, op, at);
        fill(5, 8'hA1, 0, 0, 1, 1, 0, 0);
        fill(5, 8'hB2, 0, 0, 0, 0, 0, 0);
        wait_issue(10, w, op, at);
        chk("R2 refill of occupied slot ignored", w, -1);
        writeback(5, 1);
        wait_issue(6, w, op, at);
        chk("R2 stored instruction kept", op, 8'hA1);
    endtask

    // Fill 2 (issues at once), then 20, 1, 10 while it dispatches.
    task automatic t_order(input bit mode, input int e0, input int e1, input int e2,
                           input string req);
        int w, op, at, prev;
        do_reset(mode);
        fill(2, 8'h02, 0, 0, 0, 0, 0, 0);
        fill(20, 8'h14, 0, 0, 0, 0, 0, 0);
        fill(1, 8'h01, 0, 0, 0, 0, 0, 0);
        fill(10, 8'h0A, 0, 0, 0, 0, 0, 0);
        wait_issue(6, w, op, at);
        chk(req, w, e0);
        prev = at;
        wait_issue(6, w, op, at);
        chk(req, w, e1);
        chk("R7 no gap between issues", at - prev, 4);
        prev = at;
        wait_issue(6, w, op, at);
        chk(req, w, e2);
        chk("R7 no gap between issues", at - prev, 4);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_basic();
        t_raw();
        t_waw();
        t_occupied();
        t_order(1'b0, 10, 20, 1, "R8 round-robin order");
        t_order(1'b1, 20, 1, 10, "R9 oldest-first order");
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end
endmodule